// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a simple word-request port and one single-data-rate SDRAM with four banks and a 16-bit data bus. Each accepted request carries a linear word address, a write flag and write data. The block turns it into a row open, a column read or write and a closing precharge. Every command goes out on registered chip-select, row-strobe, column-strobe and write-enable lines, with a bank select and a 13-bit address bus. Read data comes back on a response strobe once the programmed CAS latency has passed.

After reset the controller brings the device up by itself. It waits a configurable number of cycles, closes all banks, issues two auto refreshes and loads the mode register with burst length one, sequential order and a CAS latency of 2 or 3. The latency is chosen by a configuration pin. From then on a timer issues an auto refresh at a fixed interval, sized from the clock frequency so that 8192 refreshes fit inside 64 ms. The page policy is closed: every column access sets address bit 10, so the device closes the row itself. The only explicit precharge is the all-bank one issued during bring-up.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is held, the command lines show NOP (1,1,1,1), and init_done, req_ready, sd_dq_oe and rsp_valid are all 0.
- R2: After reset is released, T_PWRUP cycles of NOP pass before the first command. The bring-up commands then follow in this order, each separated from the previous command by the stated number of cycles: precharge with A10=1, then auto refresh after T_RP, then a second auto refresh after T_RC, then mode register set after T_RC. No other command is issued during bring-up. init_done rises in the cycle that carries the mode register set.
- R3: The mode register set uses bank 0. Its address word holds the CAS latency in bits 6:4 (2 when cfg_cas3=0, 3 when cfg_cas3=1), and every other bit is 0.
- R4: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as: activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode set 0000, NOP 0111.
- R5: A request address is split as {bank[23:22], row[21:9], column[8:0]}. Activate carries the bank and the row. Read or write carries the same bank, with the column in A8..A0, A10=1 and all other address bits 0.
- R6: A request is taken at a rising edge where req_valid and req_ready are both 1. The activate appears in the cycle that follows that edge. The read or write follows the activate exactly T_RCD cycles later.
- R7: Write data appears on sd_dq_out with sd_dq_oe=1 in the write-command cycle only. sd_dq_oe is 0 in every other cycle.
- R8: For a read issued in cycle c, the data on sd_dq_in is captured at the end of cycle c+CL. It is presented on rsp_rdata with rsp_valid=1 for the single cycle c+CL+1.
- R9: req_ready returns T_WR+T_RP-1 cycles after a write command, or CL+T_RP-1 cycles after a read command, unless a refresh is due.
- R10: With no traffic, successive auto refreshes are exactly REF_INT = floor(CLK_MHZ*64000/8192) cycles apart.
- R11: A refresh that becomes due while requests are waiting is issued before the next activate, in the first slot after the current access. The next activate follows it after T_RC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas3 | input | 1 | CAS latency select: 0 for 2, 1 for 3; sampled at mode set |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 24 | Linear word address {bank,row,column} |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted at this edge if valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 16 | Read data |
| init_done | output | 1 | Bring-up finished |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row, column or mode word |
| sd_dq_out | output | 16 | Write data to device |
| sd_dq_oe | output | 1 | Data bus drive enable |
| sd_dq_in | input | 16 | Read data from device |

## Verification
The hardest case to reach is a refresh that falls due while a request is already waiting. Only in that case does the priority between refresh and access decide anything. The bench reaches it by holding req_valid high on a stream of back-to-back reads for more than one full refresh interval, which puts a timer expiry inside the stream. It then checks where the refresh lands: right after the read's recovery time, ahead of the waiting activate, with that activate following it after T_RC. A device stub that honours the programmed latency returns stored data, so wrong latency or a wrong address split shows up as wrong read data as well as in the command checks.

// File: rtl/sdram_seq_ctrl.sv
module sdram_seq_ctrl #(
  parameter int CLK_MHZ = 125,
  parameter int T_PWRUP = 25000,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_RC    = 9,
  parameter int T_WR    = 2,
  parameter int T_MRD   = 2,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int DQ_W    = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_cas3,
  input  logic                            req_valid,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DQ_W-1:0]                 req_wdata,
  output logic                            req_ready,
  output logic                            rsp_valid,
  output logic [DQ_W-1:0]                 rsp_rdata,
  output logic                            init_done,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_addr,
  output logic [DQ_W-1:0]                 sd_dq_out,
  output logic                            sd_dq_oe,
  input  logic [DQ_W-1:0]                 sd_dq_in
);
  localparam int ADDR_W  = BANK_W + ROW_W + COL_W;
  localparam int REF_INT = (CLK_MHZ * 64000) / 8192;
  localparam int CNT_W   = $clog2(T_PWRUP + T_RC + T_RCD + T_WR + T_RP + T_MRD + 8);
  localparam int REF_W   = $clog2(REF_INT + 1);

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_MRS = 4'b0000;

  typedef enum logic [2:0] {S_PWR, S_IREF1, S_IREF2, S_IMRS, S_IDLE, S_RW} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        cmd_q;
  logic              cl3, wr_q, ref_pend;
  logic [BANK_W-1:0] ba_q;
  logic [COL_W-1:0]  col_q;
  logic [DQ_W-1:0]   wd_q;
  logic [REF_W-1:0]  ref_cnt;
  logic [3:0]        rd_sh;
  logic              go, rd_launch, rd_tap, ref_tick;

  assign go        = (cnt == '0);
  assign init_done = (st == S_IDLE) || (st == S_RW);
  assign req_ready = go && (st == S_IDLE) && !ref_pend;
  assign rd_launch = go && (st == S_RW) && !wr_q;
  assign rd_tap    = cl3 ? rd_sh[3] : rd_sh[2];
  assign ref_tick  = init_done && (ref_cnt == REF_W'(REF_INT - 1));
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  function automatic logic [ROW_W-1:0] col_word(input logic [COL_W-1:0] c);
    logic [ROW_W-1:0] w;
    w = '0;
    w[COL_W-1:0] = c;
    w[10] = 1'b1;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PWR;
      cnt       <= CNT_W'(T_PWRUP - 1);
      cmd_q     <= C_NOP;
      sd_ba     <= '0;
      sd_addr   <= '0;
      sd_dq_out <= '0;
      sd_dq_oe  <= 1'b0;
      cl3       <= 1'b0;
      wr_q      <= 1'b0;
      ba_q      <= '0;
      col_q     <= '0;
      wd_q      <= '0;
      ref_pend  <= 1'b0;
      ref_cnt   <= '0;
      rd_sh     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      cmd_q     <= C_NOP;
      sd_dq_oe  <= 1'b0;
      rd_sh     <= {rd_sh[2:0], rd_launch};
      rsp_valid <= rd_tap;
      if (rd_tap) rsp_rdata <= sd_dq_in;
      if (init_done) ref_cnt <= ref_tick ? '0 : ref_cnt + 1'b1;
      if (!go) cnt <= cnt - 1'b1;
      else begin
        case (st)
          S_PWR: begin
            cmd_q   <= C_PRE;
            sd_addr <= ROW_W'(1 << 10);
            cnt     <= CNT_W'(T_RP - 1);
            st      <= S_IREF1;
          end
          S_IREF1: begin
            cmd_q <= C_REF;
            cnt   <= CNT_W'(T_RC - 1);
            st    <= S_IREF2;
          end
          S_IREF2: begin
            cmd_q <= C_REF;
            cnt   <= CNT_W'(T_RC - 1);
            st    <= S_IMRS;
          end
          S_IMRS: begin
            cmd_q   <= C_MRS;
            sd_ba   <= '0;
            sd_addr <= ROW_W'({cfg_cas3 ? 3'd3 : 3'd2, 4'b0000});
            cl3     <= cfg_cas3;
            cnt     <= CNT_W'(T_MRD - 1);
            st      <= S_IDLE;
          end
          S_IDLE: begin
            if (ref_pend) begin
              cmd_q    <= C_REF;
              ref_pend <= 1'b0;
              cnt      <= CNT_W'(T_RC - 1);
            end else if (req_valid) begin
              cmd_q   <= C_ACT;
              sd_ba   <= req_addr[ADDR_W-1 -: BANK_W];
              sd_addr <= req_addr[COL_W +: ROW_W];
              ba_q    <= req_addr[ADDR_W-1 -: BANK_W];
              col_q   <= req_addr[COL_W-1:0];
              wr_q    <= req_write;
              wd_q    <= req_wdata;
              cnt     <= CNT_W'(T_RCD - 1);
              st      <= S_RW;
            end
          end
          S_RW: begin
            cmd_q   <= wr_q ? C_WR : C_RD;
            sd_ba   <= ba_q;
            sd_addr <= col_word(col_q);
            st      <= S_IDLE;
            if (wr_q) begin
              sd_dq_oe  <= 1'b1;
              sd_dq_out <= wd_q;
              cnt       <= CNT_W'(T_WR + T_RP - 1);
            end else begin
              cnt <= cl3 ? CNT_W'(2 + T_RP) : CNT_W'(1 + T_RP);
            end
          end
          default: st <= S_PWR;
        endcase
      end
      if (ref_tick) ref_pend <= 1'b1;
    end
  end

  logic [CNT_W-1:0] since_act;
  always_ff @(posedge clk) begin
    if (!rst_n) since_act <= '0;
    else if (cmd_q == C_ACT) since_act <= CNT_W'(1);
    else if (since_act != '1) since_act <= since_act + 1'b1;
  end

  AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD || cmd_q == C_WR) |-> since_act >= CNT_W'(T_RCD)); // R6
  AST_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_RD || cmd_q == C_WR) |-> sd_addr[10]); // R5
  AST_REF_BEFORE_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_ACT) |-> !$past(ref_pend)); // R11
  AST_NO_REF_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |-> !ref_pend); // R10
  AST_OE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd_q == C_WR)); // R7
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
endmodule

// File: tb/test_sdram_seq_ctrl.sv
module test_sdram_seq_ctrl;
  localparam int CLK_MHZ = 125, T_PWR = 40, T_RCD = 3, T_RP = 3, T_RC = 9, T_WR = 2, T_MRD = 2;
  localparam int REF_INT = (CLK_MHZ * 64000) / 8192;
  localparam logic [3:0] NOP = 4'b0111, ACT = 4'b0011, RD = 4'b0101, WR = 4'b0100,
                         PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  localparam logic [40:0] VEC [9] = '{
    {1'b1, 24'h000000, 16'h1111},
    {1'b1, 24'hFFFFFF, 16'hA5A5},
    {1'b1, 24'h400155, 16'h0F0F},
    {1'b1, 24'h9ABE01, 16'h7E57},
    {1'b0, 24'h000000, 16'h1111},
    {1'b0, 24'h400155, 16'h0F0F},
    {1'b0, 24'hFFFFFF, 16'hA5A5},
    {1'b1, 24'h000000, 16'hBEEF},
    {1'b0, 24'h000000, 16'hBEEF}
  };

  logic clk = 0, rst_n = 0, cfg_cas3 = 0;
  logic req_valid = 0, req_write = 0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, rsp_valid, init_done;
  logic [15:0] rsp_rdata, sd_dq_out, sd_dq_in;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [12:0] sd_addr;

  always #4 clk = ~clk;

  sdram_seq_ctrl #(.CLK_MHZ(CLK_MHZ), .T_PWRUP(T_PWR), .T_RCD(T_RCD), .T_RP(T_RP),
                   .T_RC(T_RC), .T_WR(T_WR), .T_MRD(T_MRD)) i_sdram_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .init_done(init_done), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
    .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  int cyc = 0;
  int cl = 2;
  always @(posedge clk) cyc <= cyc + 1;

  // device stub
  logic [15:0] smem [logic [23:0]];
  logic [12:0] open_row [4];
  int rd_cnt = 0;
  logic [15:0] rd_data = '0;
  assign sd_dq_in = (rd_cnt == 1) ? rd_data : 16'hDEAD;
  always @(posedge clk) begin
    if (rd_cnt != 0) rd_cnt <= rd_cnt - 1;
    case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
      ACT: open_row[sd_ba] <= sd_addr;
      WR:  smem[{sd_ba, open_row[sd_ba], sd_addr[8:0]}] = sd_dq_out;
      RD: begin
        rd_cnt  <= cl;
        rd_data <= smem.exists({sd_ba, open_row[sd_ba], sd_addr[8:0]}) ?
                   smem[{sd_ba, open_row[sd_ba], sd_addr[8:0]}] : 16'h0BAD;
      end
      default: ;
    endcase
  end

  // bus monitor
  int act_cyc, rw_cyc, pre_cyc, mrs_cyc, last_ref, prev_ref, rw_at_ref, act_after_ref;
  int rsp_cyc, rdy_rise, idone_rise, mrs_r1, mrs_r2, ref_n = 0, ncmd = 0, oe_bad = 0;
  logic [1:0] act_ba, rw_ba, mrs_ba;
  logic [12:0] act_row, rw_a, mrs_addr;
  logic [15:0] rw_dq, rsp_data;
  logic rw_wr, rw_oe, pre_a10, rdy_prev = 0, idone_prev = 0;
  logic [3:0] last_c = NOP;
  always @(negedge clk) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (req_ready && !rdy_prev) rdy_rise = cyc;
    rdy_prev = req_ready;
    if (init_done && !idone_prev) idone_rise = cyc;
    idone_prev = init_done;
    if (rsp_valid) begin rsp_cyc = cyc; rsp_data = rsp_rdata; end
    if (sd_dq_oe && c != WR) oe_bad++;
    if (c != NOP) ncmd++;
    case (c)
      ACT: begin
        act_cyc = cyc; act_ba = sd_ba; act_row = sd_addr;
        if (last_c == REF) act_after_ref = cyc - last_ref;
      end
      RD, WR: begin
        rw_cyc = cyc; rw_ba = sd_ba; rw_a = sd_addr; rw_wr = (c == WR);
        rw_oe = sd_dq_oe; rw_dq = sd_dq_out;
      end
      PRE: begin pre_cyc = cyc; pre_a10 = sd_addr[10]; end
      REF: begin prev_ref = last_ref; last_ref = cyc; rw_at_ref = rw_cyc; ref_n++; end
      MRS: begin mrs_cyc = cyc; mrs_addr = sd_addr; mrs_ba = sd_ba; mrs_r1 = prev_ref; mrs_r2 = last_ref; end
      default: ;
    endcase
    if (c != NOP) last_c = c;
  end

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [23:0] a, input logic [15:0] d);
    int acc, r0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    acc = cyc + 1; r0 = ref_n;
    @(negedge clk);
    req_valid = 0;
    repeat (24) @(negedge clk);
    chk(act_cyc == acc, "R6", "activate cycle", act_cyc, acc);
    chk({act_ba, act_row} == a[23:9], "R5", "activate bank/row", int'({act_ba, act_row}), int'(a[23:9]));
    chk(rw_cyc - act_cyc == T_RCD, "R6", "activate to column gap", rw_cyc - act_cyc, T_RCD);
    chk({rw_ba, rw_a} == {a[23:22], 13'h400 | 13'(a[8:0])}, "R5", "column command address",
        int'({rw_ba, rw_a}), int'({a[23:22], 13'h400 | 13'(a[8:0])}));
    chk(rw_wr == wr, "R4", "column command type", int'(rw_wr), int'(wr));
    if (wr) begin
      chk(rw_oe && rw_dq == d, "R7", "write data on bus", int'({rw_oe, rw_dq}), int'({1'b1, d}));
      if (ref_n == r0) chk(rdy_rise - rw_cyc == T_WR + T_RP - 1, "R9", "ready after write",
                           rdy_rise - rw_cyc, T_WR + T_RP - 1);
    end else begin
      chk(rsp_cyc - rw_cyc == cl + 1, "R8", "read response cycle", rsp_cyc - rw_cyc, cl + 1);
      chk(rsp_data == d, "R8", "read data", int'(rsp_data), int'(d));
      if (ref_n == r0) chk(rdy_rise - rw_cyc == cl + T_RP - 1, "R9", "ready after read",
                           rdy_rise - rw_cyc, cl + T_RP - 1);
    end
  endtask

  task automatic bring_up(input logic cas3);
    int rel, n0;
    @(negedge clk);
    rst_n = 0; cfg_cas3 = cas3; cl = cas3 ? 3 : 2;
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == NOP, "R1", "command in reset",
        int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(NOP));
    chk({init_done, req_ready, sd_dq_oe, rsp_valid} == 4'b0, "R1", "status in reset",
        int'({init_done, req_ready, sd_dq_oe, rsp_valid}), 0);
    rel = cyc; n0 = ncmd;
    rst_n = 1;
    repeat (T_PWR + T_RP + 2 * T_RC + T_MRD + 6) @(negedge clk);
    chk(pre_cyc - rel == T_PWR && pre_a10, "R2", "power-up wait / precharge all",
        pre_cyc - rel, T_PWR);
    chk(mrs_r1 - pre_cyc == T_RP, "R2", "precharge to refresh", mrs_r1 - pre_cyc, T_RP);
    chk(mrs_r2 - mrs_r1 == T_RC, "R2", "refresh to refresh", mrs_r2 - mrs_r1, T_RC);
    chk(mrs_cyc - mrs_r2 == T_RC, "R2", "refresh to mode set", mrs_cyc - mrs_r2, T_RC);
    chk(ncmd - n0 == 4, "R2", "bring-up command count", ncmd - n0, 4);
    chk(idone_rise == mrs_cyc, "R2", "init_done rise", idone_rise, mrs_cyc);
    chk({mrs_ba, mrs_addr} == {2'b00, 13'(cl << 4)}, "R3", "mode word",
        int'({mrs_ba, mrs_addr}), cl << 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n0, r0;
    bring_up(1'b0);

    foreach (VEC[i]) do_req(VEC[i][40], VEC[i][39:16], VEC[i][15:0]);

    // R10: idle refresh spacing
    n0 = ref_n;
    for (int i = 0; i < 4000 && ref_n < n0 + 3; i++) @(negedge clk);
    chk(last_ref - prev_ref == REF_INT, "R10", "idle refresh interval", last_ref - prev_ref, REF_INT);

    // R11: refresh falls due inside a held stream of reads
    @(negedge clk);
    r0 = ref_n;
    req_valid = 1; req_write = 0; req_addr = 24'h000000;
    repeat (REF_INT + 60) @(negedge clk);
    req_valid = 0;
    repeat (30) @(negedge clk);
    chk(ref_n > r0, "R11", "refresh during stream", ref_n - r0, 1);
    chk(last_ref - rw_at_ref == cl + T_RP, "R11", "refresh slot after read",
        last_ref - rw_at_ref, cl + T_RP);
    chk(act_after_ref == T_RC, "R11", "activate after refresh", act_after_ref, T_RC);
    chk(oe_bad == 0, "R7", "drive enable outside write", oe_bad, 0);

    bring_up(1'b1);
    do_req(1'b1, 24'h812345, 16'hC3C3);
    do_req(1'b0, 24'h812345, 16'hC3C3);
    chk(oe_bad == 0, "R7", "drive enable outside write", oe_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule